// File: doc/BRIEF.md
# Meter Front-Panel Mode and Price-Setting Controller

This block is the front-panel sequencer of a plug-in power meter. It receives single-cycle button strobes that have already been debounced (FUNCTION, COST, UP, DOWN), a level that stays high while COST is held, a one-second tick, and a flag from an external comparator that is high while measured power exceeds the overload limit. From these inputs it drives the display controls: the current view number (1 to 7), a lamp-test flag for the start-up phase, an edit flag, the index of the selected digit, a blink enable, the stored price as four BCD digits, and the overload display and alarm outputs. Measurement, arithmetic and LCD drawing are handled elsewhere.

The controller is a three-state machine. BOOT lights every segment for STARTUP_SECS ticks and then moves to SHOW (BOOT->SHOW on start-up expiry). In SHOW, FUNCTION steps through the seven views and a COST strobe jumps to view 7, the price view. Holding COST for more than HOLD_SECS ticks moves to EDIT (SHOW->EDIT on long hold). In EDIT, FUNCTION moves the digit cursor and UP/DOWN change the selected digit. A COST strobe ends the edit (EDIT->SHOW on COST), and so do IDLE_SECS ticks without any button (EDIT->SHOW on idle timeout). Both exits keep the edited price and show view 7. Overload is not a state. It is a registered override that sits on top of every state.

Top module: `meter_panel_ctrl`

## Requirements
- R1: After reset the block is in BOOT with all_seg=1, set_active=0, disp_mode=1, digit_sel=3 and price_bcd=16'h0000. Once STARTUP_SECS ticks have arrived, all_seg falls and disp_mode is 1.
- R2: During BOOT every button strobe is ignored, and disp_mode stays 1.
- R3: In SHOW, each FUNCTION strobe advances disp_mode by one, and 7 is followed by 1. The value is always within 1..7.
- R4: In SHOW, a COST strobe sets disp_mode to 7 on the next clock.
- R5: While cost_held stays high in SHOW, the block enters EDIT once HOLD_SECS+1 ticks have been counted. After only HOLD_SECS ticks it is still in SHOW. On entry, set_active=1, blink_en=1, digit_sel=3 and disp_mode=7.
- R6: In EDIT, FUNCTION moves digit_sel down by one and wraps from 0 to 3. disp_mode does not change.
- R7: price_bcd holds digit i in bits [4i+3:4i], with digit 3 the most significant. In EDIT, UP adds one to the selected digit and wraps 9 to 0. DOWN subtracts one and wraps 0 to 9. No other digit changes, and no digit ever exceeds 9.
- R8: Outside EDIT, UP and DOWN leave price_bcd unchanged.
- R9: A COST strobe in EDIT leaves EDIT on the next clock, with disp_mode=7 and the edited price kept.
- R10: In EDIT, IDLE_SECS consecutive ticks with no button strobe end the edit with disp_mode=7 and the price kept. Any button strobe restarts this count.
- R11: One clock after over_limit is sampled, overload_show and alarm equal it. While overload_show=1, blink_en and all_seg are 0, and the state and view are preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| btn_func | input | 1 | FUNCTION press strobe |
| btn_cost | input | 1 | COST press strobe |
| btn_up | input | 1 | UP press strobe |
| btn_down | input | 1 | DOWN press strobe |
| cost_held | input | 1 | High while COST is held down |
| over_limit | input | 1 | Power above overload limit |
| disp_mode | output | 3 | Display view number, 1..7 |
| all_seg | output | 1 | Start-up lamp test: light all segments |
| set_active | output | 1 | Price edit in progress |
| digit_sel | output | 2 | Selected price digit |
| blink_en | output | 1 | Blink the price field |
| price_bcd | output | 16 | Stored price, four BCD digits |
| overload_show | output | 1 | Show the overload screen |
| alarm | output | 1 | Audible alarm request |

## Verification
A wrong state register appears at the ports on the next clock. An early or late BOOT, SHOW or EDIT shows up as all_seg or set_active changing one tick too soon or too late, so the bench checks just before and just after each limit. A wrong cursor or a carry between digits shows up in price_bcd on the clock after the UP or DOWN strobe. An idle counter that fails to restart extends or shortens the edit window by whole ticks, and that is visible at set_active. A stuck overload flag keeps blink_en low, which the bench observes directly.

// File: rtl/meter_panel_pkg.sv
package meter_panel_pkg;

    typedef enum logic [1:0] {
        PH_BOOT = 2'd0,
        PH_SHOW = 2'd1,
        PH_EDIT = 2'd2
    } panel_phase_t;

    localparam int MODE_W     = 3;
    localparam logic [MODE_W-1:0] VIEW_FIRST = 3'd1;
    localparam logic [MODE_W-1:0] VIEW_LAST  = 3'd7;
    localparam logic [MODE_W-1:0] VIEW_PRICE = 3'd7;

    typedef logic [3:0] bcd_digit_t;

endpackage

// File: rtl/meter_tick_count.sv
module meter_tick_count #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Saturating count of ticks since the last clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (en && tick && (cnt != TOP)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == TOP);

endmodule

// File: rtl/meter_price_digits.sv
module meter_price_digits
    import meter_panel_pkg::*;
#(
    parameter int DIGITS = 4,
    parameter int SEL_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inc_req,
    input  logic                  dec_req,
    input  logic [SEL_W-1:0]      sel,
    output logic [4*DIGITS-1:0]   price
);
    // Each digit is an independent modulo-10 counter; no carry between them
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        bcd_digit_t d;
        logic       hit;

        assign hit = (sel == SEL_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d <= 4'd0;
            end else if (hit && inc_req) begin
                d <= (d == 4'd9) ? 4'd0 : d + 4'd1;
            end else if (hit && dec_req) begin
                d <= (d == 4'd0) ? 4'd9 : d - 4'd1;
            end
        end

        assign price[4*g +: 4] = d;
    end

endmodule

// File: rtl/meter_mode_fsm.sv
module meter_mode_fsm
    import meter_panel_pkg::*;
#(
    parameter int DIGITS = 4,
    parameter int SEL_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               btn_func,
    input  logic               btn_cost,
    input  logic               btn_up,
    input  logic               btn_down,
    input  logic               boot_done,
    input  logic               hold_done,
    input  logic               idle_done,
    input  logic               ovl_flag,
    output panel_phase_t       phase,
    output logic [MODE_W-1:0]  disp_mode,
    output logic [SEL_W-1:0]   digit_sel,
    output logic               inc_req,
    output logic               dec_req,
    output logic               all_seg,
    output logic               set_active,
    output logic               blink_en
);
    localparam logic [SEL_W-1:0] SEL_TOP = SEL_W'(DIGITS - 1);

    panel_phase_t phase_nx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_BOOT;
        end else begin
            phase <= phase_nx;
        end
    end

    // Transitions
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_BOOT: if (boot_done)              phase_nx = PH_SHOW;
            PH_SHOW: if (hold_done)              phase_nx = PH_EDIT;
            PH_EDIT: if (btn_cost || idle_done)  phase_nx = PH_SHOW;
            default:                             phase_nx = PH_BOOT;
        endcase
    end

    // Registered outputs: view number and digit cursor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_mode <= VIEW_FIRST;
            digit_sel <= SEL_TOP;
        end else begin
            unique case (phase)
                PH_BOOT: begin
                    disp_mode <= VIEW_FIRST;
                end
                PH_SHOW: begin
                    if (hold_done) begin
                        disp_mode <= VIEW_PRICE;
                        digit_sel <= SEL_TOP;
                    end else if (btn_cost) begin
                        disp_mode <= VIEW_PRICE;
                    end else if (btn_func) begin
                        disp_mode <= (disp_mode == VIEW_LAST) ? VIEW_FIRST
                                                              : disp_mode + 1'b1;
                    end
                end
                PH_EDIT: begin
                    if (btn_cost || idle_done) begin
                        disp_mode <= VIEW_PRICE;
                    end else if (btn_func) begin
                        digit_sel <= (digit_sel == '0) ? SEL_TOP
                                                       : digit_sel - 1'b1;
                    end
                end
                default: begin
                    disp_mode <= VIEW_FIRST;
                end
            endcase
        end
    end

    // Decoded flags; UP takes priority over DOWN on a simultaneous press
    always_comb begin
        inc_req    = (phase == PH_EDIT) && btn_up;
        dec_req    = (phase == PH_EDIT) && btn_down && !btn_up;
        set_active = (phase == PH_EDIT);
        all_seg    = (phase == PH_BOOT) && !ovl_flag;
        blink_en   = (phase == PH_EDIT) && !ovl_flag;
    end

endmodule

// File: rtl/meter_panel_ctrl.sv
module meter_panel_ctrl
    import meter_panel_pkg::*;
#(
    parameter int DIGITS       = 4,
    parameter int STARTUP_SECS = 60,
    parameter int HOLD_SECS    = 3,
    parameter int IDLE_SECS    = 10,
    localparam int SEL_W       = (DIGITS > 1) ? $clog2(DIGITS) : 1,
    localparam int PRICE_W     = 4 * DIGITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sec_tick,
    input  logic                btn_func,
    input  logic                btn_cost,
    input  logic                btn_up,
    input  logic                btn_down,
    input  logic                cost_held,
    input  logic                over_limit,
    output logic [2:0]          disp_mode,
    output logic                all_seg,
    output logic                set_active,
    output logic [SEL_W-1:0]    digit_sel,
    output logic                blink_en,
    output logic [PRICE_W-1:0]  price_bcd,
    output logic                overload_show,
    output logic                alarm
);
    localparam int HOLD_TICKS = HOLD_SECS + 1;

    panel_phase_t phase;
    logic boot_done, hold_done, idle_done;
    logic inc_req, dec_req;
    logic ovl_q;
    logic any_btn;

    assign any_btn = btn_func | btn_cost | btn_up | btn_down;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovl_q <= 1'b0;
        end else begin
            ovl_q <= over_limit;
        end
    end

    assign overload_show = ovl_q;
    assign alarm         = ovl_q;

    meter_tick_count #(.LIMIT(STARTUP_SECS)) u_boot_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (1'b0),
        .en   (phase == PH_BOOT),
        .tick (sec_tick),
        .done (boot_done)
    );

    meter_tick_count #(.LIMIT(HOLD_TICKS)) u_hold_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!cost_held || (phase != PH_SHOW)),
        .en   (1'b1),
        .tick (sec_tick),
        .done (hold_done)
    );

    meter_tick_count #(.LIMIT(IDLE_SECS)) u_idle_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (any_btn || (phase != PH_EDIT)),
        .en   (1'b1),
        .tick (sec_tick),
        .done (idle_done)
    );

    meter_mode_fsm #(.DIGITS(DIGITS), .SEL_W(SEL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .btn_func  (btn_func),
        .btn_cost  (btn_cost),
        .btn_up    (btn_up),
        .btn_down  (btn_down),
        .boot_done (boot_done),
        .hold_done (hold_done),
        .idle_done (idle_done),
        .ovl_flag  (ovl_q),
        .phase     (phase),
        .disp_mode (disp_mode),
        .digit_sel (digit_sel),
        .inc_req   (inc_req),
        .dec_req   (dec_req),
        .all_seg   (all_seg),
        .set_active(set_active),
        .blink_en  (blink_en)
    );

    meter_price_digits #(.DIGITS(DIGITS), .SEL_W(SEL_W)) u_price (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_req(inc_req),
        .dec_req(dec_req),
        .sel    (digit_sel),
        .price  (price_bcd)
    );

endmodule

// File: rtl/meter_panel_chk.sv
module meter_panel_chk #(
    parameter int DIGITS = 4,
    parameter int SEL_W  = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                btn_cost,
    input logic                btn_up,
    input logic                btn_down,
    input logic                over_limit,
    input logic [2:0]          disp_mode,
    input logic                all_seg,
    input logic                set_active,
    input logic [SEL_W-1:0]    digit_sel,
    input logic                blink_en,
    input logic [4*DIGITS-1:0] price_bcd,
    input logic                overload_show,
    input logic                alarm
);
    // R3
    view_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_mode >= 3'd1) && (disp_mode <= 3'd7));

    // R2
    boot_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_seg |-> (disp_mode == 3'd1));

    // R5
    edit_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(set_active) |-> (digit_sel == SEL_W'(DIGITS - 1)) && (disp_mode == 3'd7));

    // R6
    edit_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_active && $past(set_active)) |-> $stable(disp_mode));

    // R8
    price_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_active && (btn_up || btn_down)) |=> $stable(price_bcd));

    // R9
    cost_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_active && btn_cost) |=> (!set_active && (disp_mode == 3'd7)));

    // R11
    alarm_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        over_limit |=> (alarm && overload_show));

    // R11
    alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !over_limit |=> (!alarm && !overload_show));

    // R11
    override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overload_show |-> (!blink_en && !all_seg));

    for (genvar g = 0; g < DIGITS; g++) begin : g_bcd
        // R7
        bcd_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            price_bcd[4*g +: 4] <= 4'd9);
    end

endmodule

bind meter_panel_ctrl meter_panel_chk #(.DIGITS(DIGITS), .SEL_W(SEL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .btn_cost     (btn_cost),
    .btn_up       (btn_up),
    .btn_down     (btn_down),
    .over_limit   (over_limit),
    .disp_mode    (disp_mode),
    .all_seg      (all_seg),
    .set_active   (set_active),
    .digit_sel    (digit_sel),
    .blink_en     (blink_en),
    .price_bcd    (price_bcd),
    .overload_show(overload_show),
    .alarm        (alarm)
);

// File: tb/meter_panel_ctrl_test.sv
module meter_panel_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 1'b0;
    logic btn_func = 1'b0, btn_cost = 1'b0, btn_up = 1'b0, btn_down = 1'b0;
    logic cost_held = 1'b0, over_limit = 1'b0;
    logic [2:0]  disp_mode;
    logic        all_seg, set_active, blink_en, overload_show, alarm;
    logic [1:0]  digit_sel;
    logic [15:0] price_bcd;

    always #10 clk = ~clk;

    meter_panel_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .btn_func(btn_func), .btn_cost(btn_cost), .btn_up(btn_up), .btn_down(btn_down),
        .cost_held(cost_held), .over_limit(over_limit),
        .disp_mode(disp_mode), .all_seg(all_seg), .set_active(set_active),
        .digit_sel(digit_sel), .blink_en(blink_en), .price_bcd(price_bcd),
        .overload_show(overload_show), .alarm(alarm)
    );

    typedef struct packed {
        logic [2:0]  mode;
        logic        set;
        logic [1:0]  sel;
        logic [15:0] price;
        logic        seg;
        logic        blink;
        logic        ovl;
    } snap_t;

    snap_t exp_q[$];
    string tag_q[$];
    snap_t m;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Monitor: pops expected items and compares away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            snap_t e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = '{disp_mode, set_active, digit_sel, price_bcd, all_seg, blink_en, overload_show};
            checks++;
            if (a != e || alarm != e.ovl) begin
                errors++;
                $display("FAIL %s: actual mode=%0d set=%0b sel=%0d price=%h seg=%0b blink=%0b ovl=%0b alarm=%0b expected mode=%0d set=%0b sel=%0d price=%h seg=%0b blink=%0b ovl=%0b",
                         t, a.mode, a.set, a.sel, a.price, a.seg, a.blink, a.ovl, alarm,
                         e.mode, e.set, e.sel, e.price, e.seg, e.blink, e.ovl);
            end
        end
    end

    task automatic expect_now(input string tag);
        repeat (2) @(negedge clk);
        #1;
        exp_q.push_back(m);
        tag_q.push_back(tag);
    endtask

    task automatic press(input bit f, input bit c, input bit u, input bit d);
        @(negedge clk);
        btn_func = f; btn_cost = c; btn_up = u; btn_down = d;
        @(negedge clk);
        btn_func = 0; btn_cost = 0; btn_up = 0; btn_down = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sec_tick = 1'b1;
            @(negedge clk) sec_tick = 1'b0;
        end
    endtask

    task automatic long_hold_enter(input string tag_before, input string tag_after);
        @(negedge clk);
        cost_held = 1'b1; btn_cost = 1'b1;
        @(negedge clk);
        btn_cost = 1'b0;
        m.mode = 3'd7;
        ticks(3);
        expect_now(tag_before);
        ticks(1);
        m.set = 1'b1; m.sel = 2'd3; m.blink = !m.ovl;
        expect_now(tag_after);
        @(negedge clk) cost_held = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m = '{mode: 3'd1, set: 1'b0, sel: 2'd3, price: 16'h0000, seg: 1'b1, blink: 1'b0, ovl: 1'b0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_now("R1 reset state");

        press(1, 0, 0, 0);
        press(0, 1, 0, 0);
        expect_now("R2 buttons ignored during start-up");

        ticks(59);
        expect_now("R1 still lamp test before last tick");
        ticks(1);
        m.seg = 1'b0;
        expect_now("R1 start-up ends in view 1");

        for (int v = 2; v <= 7; v++) begin
            press(1, 0, 0, 0);
            m.mode = 3'(v);
            expect_now("R3 FUNCTION advances view");
        end
        press(1, 0, 0, 0);
        m.mode = 3'd1;
        expect_now("R3 view 7 wraps to 1");

        press(0, 0, 1, 0);
        press(0, 0, 0, 1);
        expect_now("R8 UP/DOWN ignored in SHOW");

        @(negedge clk) cost_held = 1'b1; btn_cost = 1'b1;
        @(negedge clk) btn_cost = 1'b0; cost_held = 1'b0;
        m.mode = 3'd7;
        expect_now("R4 short COST jumps to view 7");
        press(1, 0, 0, 0);
        m.mode = 3'd1;
        expect_now("R3 from 7 back to 1");

        long_hold_enter("R5 not yet editing at hold limit", "R5 edit entered after long hold");

        press(0, 0, 1, 0); m.price = 16'h1000;
        expect_now("R7 UP on top digit");
        press(0, 0, 0, 1); press(0, 0, 0, 1); m.price = 16'h9000;
        expect_now("R7 DOWN wraps 0 to 9");
        press(1, 0, 0, 0); m.sel = 2'd2;
        expect_now("R6 cursor moves down");
        press(0, 0, 1, 0); m.price = 16'h9100;
        expect_now("R7 UP on digit 2");
        press(1, 0, 0, 0); press(1, 0, 0, 0); m.sel = 2'd0;
        press(0, 0, 0, 1); m.price = 16'h9109;
        expect_now("R7 DOWN on digit 0 no borrow");
        press(0, 0, 1, 0); m.price = 16'h9100;
        expect_now("R7 UP wraps 9 to 0 without carry");
        press(1, 0, 0, 0); m.sel = 2'd3;
        expect_now("R6 cursor wraps 0 to 3");

        press(0, 1, 0, 0); m.set = 1'b0; m.blink = 1'b0;
        expect_now("R9 COST stores and exits");
        press(0, 0, 1, 0);
        expect_now("R8 UP ignored after exit");

        long_hold_enter("R5 second entry pending", "R5 second entry");
        ticks(8);
        expect_now("R10 still editing before idle limit");
        press(0, 0, 1, 0); m.price = 16'h0100;
        ticks(9);
        expect_now("R10 button restarted idle count");
        ticks(1);
        m.set = 1'b0; m.blink = 1'b0; m.mode = 3'd7;
        expect_now("R10 idle timeout exits to view 7");

        @(negedge clk) over_limit = 1'b1;
        m.ovl = 1'b1;
        expect_now("R11 overload flag and alarm");
        long_hold_enter("R11 overload hold pending", "R11 edit under overload no blink");
        @(negedge clk) over_limit = 1'b0;
        m.ovl = 1'b0; m.blink = 1'b1;
        expect_now("R11 blink returns after overload");
        press(0, 1, 0, 0); m.set = 1'b0; m.blink = 1'b0;
        expect_now("R9 exit after overload cleared");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule